// File: doc/BRIEF.md
# Mid-Frame Pattern Page Splitter

This block sits between the picture processor's pattern-table address and an 8 KB pattern RAM. The RAM holds two 4 KB pages. Normally address bit 12 passes straight through, so the lower and upper halves of pattern space map to pages 0 and 1. In split mode, the upper page is shown in both halves for a fixed band of the frame.

The block counts scanlines by filtering rising edges of the PPU's A12 line. A rising edge only counts when A12 was low for at least `MIN_LOW` clock cycles before it. Rendering must also be on. When the enable bit is set, the line that brings the count to `SPLIT_LINE` (127) starts the split. From then on, pattern-RAM A12 is forced high. The line that brings the count to `END_LINE` (239) ends the split. A CPU write that clears the enable bit cancels a split in progress, but only while the count is still below `SPLIT_LINE + 1`.

A small state machine tracks the frame. It has three states:

- **ST_WAIT**: normal mapping, the split has not started yet.
- **ST_SPLIT**: both halves are mapped to page 1.
- **ST_HOLD**: normal mapping, the split is over for this frame.

It has these transitions:

- **T_START** (ST_WAIT → ST_SPLIT): a counted line makes the count 127 while the stored enable is set.
- **T_END** (ST_SPLIT → ST_HOLD): a counted line makes the count 239.
- **T_CANCEL** (ST_SPLIT → ST_HOLD): a write with enable clear arrives while the count is at most 127.
- **T_FRAME** (any state → ST_WAIT): the frame-start pulse.

Top module: `chr_page_splitter`

## Requirements
- R1: After reset the state is ST_WAIT, the line count is 0 and `chr_a12` equals `ppu_a12`.
- R2: Outside ST_SPLIT, `chr_a12` equals `ppu_a12` in the same cycle.
- R3: A rising edge of `ppu_a12` advances the line count by exactly one when three conditions hold: `render_en` is high, `ppu_a12` was low on the previous clock, and it had been low for at least `MIN_LOW` (3) consecutive clocks. Any shorter low pulse is not counted.
- R4: While `render_en` is low the line count does not change, apart from a clear by `frame_start`.
- R5: `frame_start` clears the line count to 0 and returns the state to ST_WAIT on the next clock, whatever the current state.
- R6: From the clock after the edge that makes the count 127, with the stored enable set, `chr_a12` is 1 while `render_en` is high.
- R7: From the clock after the edge that makes the count 239, the split is over and `chr_a12` follows `ppu_a12` until the next frame start.
- R8: In ST_SPLIT, a write with `cpu_split_en` = 0 while the count is below 128 ends the split on the next clock. Such a write at count 128 or above leaves the split in place.
- R9: In ST_SPLIT with `render_en` low, `chr_a12` follows `ppu_a12`.
- R10: A write stores `cpu_split_en` on the clock it is sampled; only the stored value gates T_START. Setting the enable after the count has passed 127 starts no split in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PPU-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| render_en | input | 1 | Rendering enabled status |
| ppu_a12 | input | 1 | PPU pattern address bit 12 |
| cpu_wr | input | 1 | One-cycle CPU write strobe to the bank register |
| cpu_split_en | input | 1 | Enable bit value carried by the write |
| chr_a12 | output | 1 | Pattern RAM address bit 12 |

## Verification
The bench feeds whole frames of A12 activity and injects short low glitches on A12. A design that counted those glitches would start the split several lines early. It also turns rendering off inside and before the split band. A wrong design there would either keep counting and shift the band, or keep forcing A12 while the display is off. Disabling writes are placed exactly on line 127 and again after line 128. A design with the wrong compare bound would cancel too late, or would cancel a split it must keep. Mid-split frame restarts and late enables check that no split leaks past T_FRAME or starts after its line has gone by.

// File: rtl/chr_split_pkg.sv
package chr_split_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_SPLIT = 2'd1,
        ST_HOLD  = 2'd2
    } split_state_t;
endpackage

// File: rtl/chr_a12_edge_filter.sv
module chr_a12_edge_filter #(
    parameter int MIN_LOW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ppu_a12,
    input  logic render_en,
    output logic line_tick
);
    localparam int LOW_W = $clog2(MIN_LOW + 1);
    localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(MIN_LOW);

    logic             a12_prev;
    logic [LOW_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a12_prev <= 1'b0;
            low_run  <= '0;
        end else begin
            a12_prev <= ppu_a12;
            if (ppu_a12)
                low_run <= '0;
            else if (low_run != LOW_SAT)
                low_run <= low_run + 1'b1;
        end
    end

    assign line_tick = render_en && ppu_a12 && !a12_prev && (low_run == LOW_SAT);
endmodule

// File: rtl/chr_line_counter.sv
module chr_line_counter #(
    parameter int LINE_W     = 9,
    parameter int SPLIT_LINE = 127,
    parameter int END_LINE   = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_tick,
    output logic [LINE_W-1:0] line_cnt,
    output logic              reach_split,
    output logic              reach_end,
    output logic              cancel_window
);
    localparam logic [LINE_W-1:0] CNT_MAX   = {LINE_W{1'b1}};
    localparam logic [LINE_W-1:0] SPLIT_PRE = LINE_W'(SPLIT_LINE - 1);
    localparam logic [LINE_W-1:0] END_PRE   = LINE_W'(END_LINE - 1);
    localparam logic [LINE_W-1:0] CANCEL_LT = LINE_W'(SPLIT_LINE + 1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            line_cnt <= '0;
        else if (frame_start)
            line_cnt <= '0;
        else if (line_tick && line_cnt != CNT_MAX)
            line_cnt <= line_cnt + 1'b1;
    end

    assign reach_split   = line_tick && (line_cnt == SPLIT_PRE);
    assign reach_end     = line_tick && (line_cnt == END_PRE);
    assign cancel_window = (line_cnt < CANCEL_LT);
endmodule

// File: rtl/chr_split_fsm.sv
module chr_split_fsm
    import chr_split_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic render_en,
    input  logic reach_split,
    input  logic reach_end,
    input  logic cancel_window,
    input  logic cpu_wr,
    input  logic cpu_split_en,
    output logic split_active,
    output logic force_high
);
    split_state_t state_q, state_d;
    logic         en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cpu_wr)
                en_q <= cpu_split_en;
        end
    end

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_WAIT:  if (reach_split && en_q) state_d = ST_SPLIT;
                ST_SPLIT: begin
                    if (cpu_wr && !cpu_split_en && cancel_window)
                        state_d = ST_HOLD;
                    else if (reach_end)
                        state_d = ST_HOLD;
                end
                ST_HOLD:  state_d = ST_HOLD;
                default:  state_d = ST_WAIT;
            endcase
        end
    end

    always_comb begin
        split_active = (state_q == ST_SPLIT);
        force_high   = split_active && render_en;
    end
endmodule

// File: rtl/chr_page_splitter.sv
module chr_page_splitter #(
    parameter int MIN_LOW    = 3,
    parameter int LINE_W     = 9,
    parameter int SPLIT_LINE = 127,
    parameter int END_LINE   = 239
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic render_en,
    input  logic ppu_a12,
    input  logic cpu_wr,
    input  logic cpu_split_en,
    output logic chr_a12
);
    logic              line_tick;
    logic [LINE_W-1:0] line_cnt;
    logic              reach_split, reach_end, cancel_window;
    logic              split_active, force_high;

    chr_a12_edge_filter #(.MIN_LOW(MIN_LOW)) filt_i (
        .clk(clk), .rst_n(rst_n), .ppu_a12(ppu_a12),
        .render_en(render_en), .line_tick(line_tick)
    );

    chr_line_counter #(
        .LINE_W(LINE_W), .SPLIT_LINE(SPLIT_LINE), .END_LINE(END_LINE)
    ) cnt_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_tick(line_tick), .line_cnt(line_cnt),
        .reach_split(reach_split), .reach_end(reach_end),
        .cancel_window(cancel_window)
    );

    chr_split_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .render_en(render_en), .reach_split(reach_split),
        .reach_end(reach_end), .cancel_window(cancel_window),
        .cpu_wr(cpu_wr), .cpu_split_en(cpu_split_en),
        .split_active(split_active), .force_high(force_high)
    );

    assign chr_a12 = force_high | ppu_a12;
endmodule

// File: rtl/chr_page_splitter_chk.sv
module chr_page_splitter_chk #(
    parameter int LINE_W     = 9,
    parameter int SPLIT_LINE = 127,
    parameter int END_LINE   = 239
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              render_en,
    input logic              ppu_a12,
    input logic              chr_a12,
    input logic [LINE_W-1:0] line_cnt,
    input logic              split_active
);
    assert_frame_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (line_cnt == '0 && !split_active));

    assert_hold_when_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!render_en && !frame_start) |=> $stable(line_cnt));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (line_cnt == $past(line_cnt) || line_cnt == $past(line_cnt) + 1'b1));

    assert_band_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        split_active |-> (line_cnt >= LINE_W'(SPLIT_LINE) && line_cnt < LINE_W'(END_LINE)));

    assert_dark_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !render_en |-> (chr_a12 == ppu_a12));

    assert_normal_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !split_active |-> (chr_a12 == ppu_a12));
endmodule

bind chr_page_splitter chr_page_splitter_chk #(
    .LINE_W(LINE_W), .SPLIT_LINE(SPLIT_LINE), .END_LINE(END_LINE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .render_en(render_en), .ppu_a12(ppu_a12), .chr_a12(chr_a12),
    .line_cnt(line_cnt), .split_active(split_active)
);

// File: tb/chr_page_splitter_tb.sv
module chr_page_splitter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_LOW    = 3;
    localparam int LINES      = 262;

    logic clk = 1'b0;
    logic rst_n, frame_start, render_en, ppu_a12, cpu_wr, cpu_split_en;
    logic chr_a12;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state: 0 wait, 1 split, 2 hold
    int m_state, m_line, m_low;
    bit m_prev, m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    chr_page_splitter dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .render_en(render_en), .ppu_a12(ppu_a12), .cpu_wr(cpu_wr),
        .cpu_split_en(cpu_split_en), .chr_a12(chr_a12)
    );

    function automatic bit exp_out(int st, bit re, bit a);
        return (st == 1 && re) ? 1'b1 : a;
    endfunction

    task automatic check(bit act, bit exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: chr_a12 actual=%0b expected=%0b (line %0d)", tag, act, exp, m_line);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_line = 0; m_low = 0; m_prev = 0; m_en = 0;
    endtask

    task automatic step(bit fs, bit re, bit a, bit wr, bit wd, string tag);
        bit tick;
        frame_start = fs; render_en = re; ppu_a12 = a; cpu_wr = wr; cpu_split_en = wd;
        #1;
        check(chr_a12, exp_out(m_state, re, a), tag);
        @(posedge clk);
        tick = re && a && !m_prev && (m_low >= MIN_LOW);
        if (fs) m_state = 0;
        else if (m_state == 0) begin
            if (tick && m_line == 126 && m_en) m_state = 1;
        end else if (m_state == 1) begin
            if (wr && !wd && m_line < 128) m_state = 2;
            else if (tick && m_line == 238) m_state = 2;
        end
        if (fs) m_line = 0;
        else if (tick && m_line < 511) m_line++;
        m_low  = a ? 0 : ((m_low >= MIN_LOW) ? MIN_LOW : m_low + 1);
        m_prev = a;
        if (wr) m_en = wd;
        @(negedge clk);
    endtask

    // one frame: optional enable write, write at wr_line, dark band, glitches, restart
    task automatic frame(string tag, int en0, int wr_line, bit wr_val,
                         int dark_lo, int dark_hi, int glitch_pct, int fs_line);
        step(1, 1, 0, 0, 0, tag);
        if (en0 >= 0) step(0, 1, 0, 1, en0[0], tag);
        for (int l = 0; l < LINES; l++) begin
            bit re;
            re = !(l >= dark_lo && l <= dark_hi);
            if (l == fs_line) step(1, re, 0, 0, 0, tag);
            for (int c = 0; c < 6; c++)
                step(0, re, 0, (l == wr_line && c == 0), wr_val, tag);
            step(0, re, 1, 0, 0, tag);
            step(0, re, 1, 0, 0, tag);
            if (($urandom % 100) < glitch_pct) begin
                int w;
                w = 1 + ($urandom % (MIN_LOW - 1));
                for (int g = 0; g < w; g++) step(0, re, 0, 0, 0, tag);
                step(0, re, 1, 0, 0, tag);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; frame_start = 0; render_en = 0; ppu_a12 = 0; cpu_wr = 0; cpu_split_en = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: passthrough right after reset, both levels
        ppu_a12 = 1; render_en = 1; #1; check(chr_a12, 1'b1, "R1");
        ppu_a12 = 0; #1; check(chr_a12, 1'b0, "R1");
        @(negedge clk);

        frame("R6", 1, -1, 0, -1, -1, 0, -1);      // plain split band, R7 end at 239
        frame("R7", -1, -1, 0, -1, -1, 0, -1);     // enable kept, band again
        frame("R2", 0, -1, 0, -1, -1, 0, -1);      // disabled: pure passthrough
        frame("R8", 1, 127, 0, -1, -1, 0, -1);     // cancel on line 127
        frame("R8", 1, 150, 0, -1, -1, 0, -1);     // late disable keeps split
        frame("R4", 1, -1, 0, 50, 59, 0, -1);      // counter frozen while dark
        frame("R9", 1, -1, 0, 150, 160, 0, -1);    // dark inside split
        frame("R3", 1, -1, 0, -1, -1, 40, -1);     // short low glitches ignored
        frame("R10", 0, 130, 1, -1, -1, 0, -1);    // enable after 127: no split
        frame("R5", 1, -1, 0, -1, -1, 0, 180);     // restart mid-split
        for (int k = 0; k < 4; k++)
            frame("R2", $urandom % 2, 100 + ($urandom % 60), $urandom % 2,
                  $urandom % 262, $urandom % 262, $urandom % 30, -1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule